// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Compression Logic

This block is the device-side control of a small dynamic memory model with a 4-bit data path, sampled by a system clock. Each falling edge of the row strobe is decoded from the column strobe and write-enable levels. CAS high opens a row for ordinary accesses. CAS low with write-enable high is a CBR refresh. CAS low with write-enable also low enters the compressed test mode. A row cycle in which CAS never falls before RAS rises is a RAS-only refresh.

Outside test mode, each column strobe reads or writes one 4-bit word at the full row and column address. Fast-page sequences, early writes and read-modify-write cycles are all supported. In test mode the array behaves as a 16-bit-wide part with a quarter of the depth. A write copies each data pin into the same bit of all four words whose column addresses differ only in the two low bits. A read reports, for each pin, whether those four cells agree. Test mode is left only through a refresh cycle.

Top module: `dram_cmp_core`

## Requirements
- R1: After synchronous reset (rst_n low), test_mode is 0, cyc_class is 0 (idle) and dq_oe is 0.
- R2: Outside test mode, a CAS fall with we_n high reads the word at {row, column}. A CAS fall with we_n low stores dq_in at that word and does not enable the output.
- R3: CAS low and we_n low at a RAS fall set test_mode and show cyc_class 3 while RAS stays low.
- R4: CAS low and we_n high at a RAS fall show cyc_class 2 and clear test_mode.
- R5: CAS high at a RAS fall shows cyc_class 1. When RAS rises with no CAS fall in that cycle, test_mode clears. A cycle that did strobe CAS leaves test_mode unchanged.
- R6: Refresh and test-entry cycles (cyc_class 2 or 3) never raise dq_oe and leave the stored data unchanged.
- R7: In test mode, a write ignores column bits [1:0] and stores dq_in into all four words of that column group.
- R8: In test mode, a read drives pin j high when bit j of the four words in the addressed group is equal, and low otherwise.
- R9: Several CAS pulses under one low RAS access different columns of the same latched row (fast page).
- R10: If we_n falls while CAS is held low after a read, dq_in is written to the column latched at the CAS fall, and the output keeps the data that was read.
- R11: dq_oe rises one clock after a read CAS fall while oe_n is low, and it drops one clock after CAS rises. dq_out is 0 whenever dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data or per-pin match flags |
| dq_oe | output | 1 | Output drive enable |
| test_mode | output | 1 | Compressed test mode active |
| cyc_class | output | 2 | Current cycle: 0 idle, 1 row, 2 CBR refresh, 3 test entry |

## Verification
The hardest case to reach is a test-mode read that reports a mismatch. This needs a group of four words that disagree in some bits, and a test-mode write can only make them agree. The stimulus fills a group with a test-mode write, leaves test mode through a RAS-only cycle, and overwrites one word with a normal write. It then re-enters test mode with a WCBR cycle and reads the group. The expected per-pin flags come from a reference copy of the memory kept in the bench.

// File: rtl/dram_cmp_core.sv
module dram_cmp_core #(
  parameter int ADDR_W = 4,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              test_mode,
  output logic [1:0]        cyc_class
);
  localparam int GRP_W = 2;
  localparam int GRP_N = 1 << GRP_W;
  localparam int IDX_W = 2 * ADDR_W;
  localparam int WORDS = 1 << IDX_W;
  localparam logic [1:0] C_IDLE = 2'd0;
  localparam logic [1:0] C_ROW  = 2'd1;
  localparam logic [1:0] C_CBR  = 2'd2;
  localparam logic [1:0] C_TSET = 2'd3;

  logic [DQ_W-1:0]   mem [WORDS];
  logic              ras_d, cas_d, we_d;
  logic [1:0]        cls_q;
  logic              tm_q, cas_seen_q, rd_valid_q;
  logic [ADDR_W-1:0] row_q, col_q;
  logic [DQ_W-1:0]   rd_q, g_and, g_or, rd_next;

  wire ras_fall = ras_d & ~ras_n;
  wire ras_rise = ~ras_d & ras_n;
  wire cas_fall = cas_d & ~cas_n;
  wire we_fall  = we_d & ~we_n;
  wire in_row   = (cls_q == C_ROW) & ~ras_n;
  wire acc      = in_row & cas_fall;
  wire dly_wr   = rd_valid_q & in_row & ~cas_n & we_fall;
  wire wr_go    = (acc & ~we_n) | dly_wr;
  wire [ADDR_W-1:0] wcol = acc ? addr : col_q;

  always_comb begin
    g_and = '1;
    g_or  = '0;
    for (int k = 0; k < GRP_N; k++) begin
      g_and = g_and & mem[{row_q, addr[ADDR_W-1:GRP_W], GRP_W'(k)}];
      g_or  = g_or  | mem[{row_q, addr[ADDR_W-1:GRP_W], GRP_W'(k)}];
    end
    rd_next = tm_q ? (g_and | ~g_or) : mem[{row_q, addr}];
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < GRP_N; k++)
      if (wr_go && (tm_q || wcol[GRP_W-1:0] == GRP_W'(k)))
        mem[{row_q, wcol[ADDR_W-1:GRP_W], GRP_W'(k)}] <= dq_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_d      <= 1'b1;
      cas_d      <= 1'b1;
      we_d       <= 1'b1;
      cls_q      <= C_IDLE;
      tm_q       <= 1'b0;
      cas_seen_q <= 1'b0;
      rd_valid_q <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      rd_q       <= '0;
    end else begin
      ras_d <= ras_n;
      cas_d <= cas_n;
      we_d  <= we_n;
      if (ras_fall) begin
        row_q      <= addr;
        cas_seen_q <= 1'b0;
        if (cas_n)     cls_q <= C_ROW;
        else if (we_n) cls_q <= C_CBR;
        else           cls_q <= C_TSET;
        if (!cas_n) tm_q <= ~we_n;
      end else if (ras_rise) begin
        cls_q <= C_IDLE;
        if (cls_q == C_ROW && !cas_seen_q) tm_q <= 1'b0;
      end
      if (acc) begin
        cas_seen_q <= 1'b1;
        col_q      <= addr;
      end
      if (ras_n || cas_n) rd_valid_q <= 1'b0;
      else if (acc && we_n) begin
        rd_valid_q <= 1'b1;
        rd_q       <= rd_next;
      end
    end
  end

  assign dq_oe     = rd_valid_q & ~oe_n;
  assign dq_out    = dq_oe ? rd_q : '0;
  assign test_mode = tm_q;
  assign cyc_class = cls_q;
endmodule

module dram_cmp_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       dq_oe,
  input logic       test_mode,
  input logic [1:0] cyc_class,
  input logic       cas_seen
);
  a_r3_wcbr_enters: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n && !we_n) |=> test_mode);
  a_r4_cbr_exits: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n && we_n) |=> !test_mode);
  a_r5_ronly_exits: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && cyc_class == 2'd1 && !cas_seen) |=> !test_mode);
  a_r5_access_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && cyc_class == 2'd1 && cas_seen) |=> test_mode == $past(test_mode));
  a_r6_refresh_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_class[1]) |-> !dq_oe);
  a_r11_cas_rise_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |=> !dq_oe);
endmodule

bind dram_cmp_core dram_cmp_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .dq_oe(dq_oe), .test_mode(test_mode), .cyc_class(cyc_class),
  .cas_seen(cas_seen_q)
);

// File: tb/dram_cmp_core_tb.sv
module dram_cmp_core_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [3:0] addr = '0, dq_in = '0;
  logic [3:0] dq_out;
  logic dq_oe, test_mode;
  logic [1:0] cyc_class;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [3:0] ref_mem [256];
  bit exp_tm = 1'b0;
  logic [3:0] exp_q [$];
  string tag_q [$];

  always #5 clk = ~clk;

  dram_cmp_core dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .test_mode(test_mode), .cyc_class(cyc_class)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic smp(); @(posedge clk); #3; endtask

  function automatic logic [3:0] tcmp(logic [3:0] row, logic [3:0] col);
    logic [3:0] a = 4'hF, o = 4'h0;
    for (int k = 0; k < 4; k++) begin
      a = a & ref_mem[{row, col[3:2], 2'(k)}];
      o = o | ref_mem[{row, col[3:2], 2'(k)}];
    end
    return a | ~o;
  endfunction

  task automatic ref_wr(logic [3:0] row, logic [3:0] col, logic [3:0] d);
    if (exp_tm) for (int k = 0; k < 4; k++) ref_mem[{row, col[3:2], 2'(k)}] = d;
    else ref_mem[{row, col}] = d;
  endtask

  task automatic push_rd(logic [3:0] row, logic [3:0] col, string tag);
    exp_q.push_back(exp_tm ? tcmp(row, col) : ref_mem[{row, col}]);
    tag_q.push_back(tag);
  endtask

  // monitor: compare every new read burst against the scoreboard
  always @(posedge clk) begin
    static logic prev = 1'b0;
    #3;
    if (rst_n && dq_oe && !prev) begin
      if (exp_q.size() == 0) chk("R2 unexpected drive", {4'h0, dq_out}, 8'hFF);
      else chk(tag_q.pop_front(), {4'h0, dq_out}, {4'h0, exp_q.pop_front()});
    end
    prev = dq_oe;
  end

  task automatic rw(logic [3:0] row, logic [3:0] col, bit wr, logic [3:0] d, string tag);
    step(); addr = row; ras_n = 1'b0;
    step(); addr = col; we_n = !wr; dq_in = d; cas_n = 1'b0;
    if (!wr) push_rd(row, col, tag);
    smp();
    if (wr) begin chk({tag, " early write no drive"}, 8'(dq_oe), 8'h0); ref_wr(row, col, d); end
    step(); cas_n = 1'b1; we_n = 1'b1;
    smp();
    chk("R11 drive off after CAS rise", {3'h0, dq_oe, dq_out}, 8'h0);
    step(); ras_n = 1'b1;
    step();
  endtask

  task automatic refresh(bit wcbr, logic [1:0] exp_cls, bit exp_t, string tag);
    step(); cas_n = 1'b0; we_n = !wcbr;
    step(); ras_n = 1'b0;
    smp();
    chk({tag, " class"}, 8'(cyc_class), 8'(exp_cls));
    chk({tag, " mode"}, 8'(test_mode), 8'(exp_t));
    chk("R6 no drive in refresh", 8'(dq_oe), 8'h0);
    step(); step(); ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    step();
    exp_tm = exp_t;
  endtask

  initial begin
    repeat (3) step();
    smp();
    chk("R1 test_mode", 8'(test_mode), 8'h0);
    chk("R1 cyc_class", 8'(cyc_class), 8'h0);
    chk("R1 dq_oe", 8'(dq_oe), 8'h0);
    step(); rst_n = 1'b1;

    rw(4'd2, 4'd5, 1, 4'hA, "R2");
    rw(4'd2, 4'd6, 1, 4'h3, "R2");
    rw(4'd7, 4'd15, 1, 4'hC, "R2");
    rw(4'd2, 4'd5, 0, 0, "R2 read 2/5");
    rw(4'd7, 4'd15, 0, 0, "R2 read 7/15");

    // fast page: two writes and three reads under one RAS low
    step(); addr = 4'd2; ras_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      logic [3:0] c;
      c = (i == 0) ? 4'd8 : (i == 1) ? 4'd9 : (i == 2) ? 4'd5 : (i == 3) ? 4'd8 : 4'd9;
      step(); addr = c; we_n = (i > 1); dq_in = 4'h1 + 4'(i) * 4'h4; cas_n = 1'b0;
      if (i < 2) ref_wr(4'd2, c, dq_in); else push_rd(4'd2, c, "R9 page read");
      step(); cas_n = 1'b1; we_n = 1'b1;
      step();
    end
    ras_n = 1'b1; step();

    // read-modify-write on 2/6
    step(); addr = 4'd2; ras_n = 1'b0;
    step(); addr = 4'd6; cas_n = 1'b0; push_rd(4'd2, 4'd6, "R10 rmw read");
    step(); dq_in = 4'h5; we_n = 1'b0; addr = 4'd0;
    smp();
    chk("R10 output holds read data", {4'h0, dq_out}, 8'h03);
    step(); we_n = 1'b1; cas_n = 1'b1;
    step(); ras_n = 1'b1; step();
    ref_wr(4'd2, 4'd6, 4'h5);
    rw(4'd2, 4'd6, 0, 0, "R10 rmw stored");

    refresh(1'b0, 2'd2, 1'b0, "R4 cbr");
    rw(4'd2, 4'd5, 0, 0, "R6 data kept after cbr");

    refresh(1'b1, 2'd3, 1'b1, "R3 wcbr");
    rw(4'd4, 4'd1, 1, 4'h9, "R7 test write");
    chk("R5 access keeps test mode", 8'(test_mode), 8'h1);
    rw(4'd4, 4'd2, 0, 0, "R8 test read match");

    // RAS-only exits test mode
    step(); addr = 4'd4; ras_n = 1'b0;
    smp();
    chk("R5 ras-only class", 8'(cyc_class), 8'h1);
    step(); step(); ras_n = 1'b1;
    smp();
    chk("R5 ras-only exits", 8'(test_mode), 8'h0);
    exp_tm = 1'b0;
    step();

    rw(4'd4, 4'd0, 0, 0, "R7 group cell 0");
    rw(4'd4, 4'd3, 0, 0, "R7 group cell 3");
    rw(4'd4, 4'd2, 1, 4'hB, "R2");

    refresh(1'b1, 2'd3, 1'b1, "R3 wcbr again");
    rw(4'd4, 4'd0, 0, 0, "R8 test read mismatch");
    refresh(1'b0, 2'd2, 1'b0, "R4 cbr exit");
    rw(4'd4, 4'd2, 0, 0, "R6 data kept after entry");
    rw(4'd4, 4'd1, 0, 0, "R7 group cell 1");

    repeat (4) step();
    chk("R11 scoreboard drained", 8'(exp_q.size()), 8'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1..: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule